// File: doc/BRIEF.md
# Shortened Reed-Solomon Parity Encoder

This block turns a stream of 188-byte packets into 204-byte Reed-Solomon codewords. It works over 8-bit symbols. The host sends each packet followed by 16 empty byte slots. The block passes the message bytes through untouched and writes the 16 computed check bytes into the empty slots. The value the host places on the data bus during those slots has no effect. Data, valid and phase all leave the block after the same fixed number of clock cycles.

Two framing conventions are supported and chosen by a static mode pin. In the first, the phase input is high over the message and drops when the check slots begin. In the second, phase stays high for the whole codeword, and the block counts message bytes to find where the check slots start. A bypass pin switches the block to pass-through at the same latency.

The check bytes are the remainder of the message polynomial, times x^16, divided by the generator polynomial. The field is generated by x^8+x^4+x^3+x^2+1 with primitive element 2. The generator is the product of (x + 2^i) for i = 0 to 15. The encoder state is cleared at the first message byte of every codeword.

Top module: `rs_parity_inserter`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_phase and out_data are all zero after that edge.
- R2: Within a codeword, the message bytes leave unchanged. The check slots carry the remainder of the message times x^16 divided by the generator, highest-degree coefficient first. As a result, the 204-byte output evaluates to zero at 2^i for every i from 0 to 15, with the first output byte as the highest-degree coefficient.
- R3: The in_data value during a check slot does not influence any output byte.
- R4: out_data, out_valid and out_phase follow their inputs after exactly 2 clock cycles (default parameters).
- R5: With bypass high, every byte leaves unchanged, including the bytes in check slots, at the same 2-cycle latency.
- R6: With span_mode = 0, the first valid byte with in_phase high after in_phase was low starts a codeword. Up to 16 later valid bytes with in_phase low are check slots.
- R7: With span_mode = 1, in_phase is high for all 204 bytes. The first 188 valid bytes are the message and the next 16 valid bytes are check slots.
- R8: The encoder state is cleared at every codeword start. A codeword abandoned part way has no effect on the check bytes of the next codeword.
- R9: Cycles with in_valid low do not advance the encoder. Any number of idle cycles between bytes leaves the check bytes unchanged.
- R10: With span_mode = 0, valid bytes with in_phase low that arrive after all 16 check slots are used leave unchanged, with out_phase low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bypass | input | 1 | 1: pass all bytes unchanged |
| span_mode | input | 1 | 0: phase falls at first check slot; 1: phase high over whole codeword |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte is valid |
| in_phase | input | 1 | Message-phase framing |
| out_data | output | 8 | Output byte with check bytes inserted |
| out_valid | output | 1 | Delayed in_valid |
| out_phase | output | 1 | Delayed in_phase |

## Verification
The bench uses the default parameters: 188 message bytes, 16 check bytes, the field polynomial 0x11D and one extra output stage. It therefore checks real full-length codewords and the 2-cycle latency. It computes check bytes with its own long division and also confirms that all sixteen syndromes are zero. It covers both framing modes, different filler values, idle gaps, an abandoned codeword followed by a fresh one, and trailing bytes outside any codeword. Other message and check lengths are reached only through the parameters and the derived counter widths.

// File: rtl/rs_enc_pkg.sv
// Shared definitions for the parity encoder: slot classification and
// GF(2^8) multiplication. Assumes the field polynomial has bit 8 set.
package rs_enc_pkg;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_MSG  = 2'd1,
        SLOT_PAR  = 2'd2
    } slot_e;

    // Multiply two field elements, reducing by the given field polynomial.
    function automatic logic [7:0] gf_mul(input logic [7:0] a,
                                          input logic [7:0] b,
                                          input logic [8:0] poly);
        logic [7:0] acc;
        logic [7:0] x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x[7] ? ((x << 1) ^ poly[7:0]) : (x << 1);
        end
        return acc;
    endfunction

endpackage

// File: rtl/rs_delay_line.sv
// Fixed shift register of DEPTH stages, DEPTH may be zero (wire through).
// Assumes synchronous active-low reset clears every stage.
module rs_delay_line #(
    parameter int W     = 10,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] taps [DEPTH];

            // Shift the word one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
                end else begin
                    taps[0] <= d;
                    for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
                end
            end

            assign q = taps[DEPTH-1];

            a_r4_first_tap_follows: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> taps[0] == $past(d));
        end
    endgenerate

endmodule

// File: rtl/rs_slot_tracker.sv
// Classifies each input byte as message, check slot or neither.
// Assumes span_mode is static while a codeword is in flight.
module rs_slot_tracker
    import rs_enc_pkg::*;
#(
    parameter int MSG_LEN = 188,
    parameter int NPAR    = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  span_mode,
    input  logic  in_valid,
    input  logic  in_phase,
    output slot_e slot,
    output logic  start,
    output logic  last_par
);

    localparam int CW = $clog2(MSG_LEN + 1);
    localparam int PW = $clog2(NPAR + 1);
    localparam logic [CW-1:0] MSG_LIM = CW'(MSG_LEN);
    localparam logic [PW-1:0] PAR_LIM = PW'(NPAR);

    logic          armed;
    logic [CW-1:0] msg_cnt;
    logic [PW-1:0] par_cnt;
    logic          msg_room;
    logic          par_room;

    // Decide the role of the byte presented this cycle.
    always_comb begin
        start    = in_valid && in_phase && armed;
        msg_room = msg_cnt < MSG_LIM;
        par_room = par_cnt < PAR_LIM;
        slot     = SLOT_NONE;
        if (in_valid) begin
            if (start) begin
                slot = SLOT_MSG;
            end else if (span_mode) begin
                if (in_phase) begin
                    if (msg_room)      slot = SLOT_MSG;
                    else if (par_room) slot = SLOT_PAR;
                end
            end else begin
                if (in_phase)      slot = SLOT_MSG;
                else if (par_room) slot = SLOT_PAR;
            end
        end
        last_par = (slot == SLOT_PAR) && (par_cnt == PAR_LIM - PW'(1));
    end

    // Arm a new codeword start whenever the phase input is seen low.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed <= 1'b1;
        else if (!in_phase)        armed <= 1'b1;
        else if (in_valid)         armed <= 1'b0;
    end

    // Count message bytes of the current codeword (saturating at MSG_LEN).
    always_ff @(posedge clk) begin
        if (!rst_n)                                  msg_cnt <= '0;
        else if (start)                              msg_cnt <= CW'(1);
        else if (slot == SLOT_MSG && msg_room)       msg_cnt <= msg_cnt + CW'(1);
    end

    // Count check slots used; starts full so no slots exist before a codeword.
    always_ff @(posedge clk) begin
        if (!rst_n)                par_cnt <= PAR_LIM;
        else if (start)            par_cnt <= '0;
        else if (slot == SLOT_PAR) par_cnt <= par_cnt + PW'(1);
    end

    a_r8_start_clears_counts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (msg_cnt == CW'(1)) && (par_cnt == '0));

    a_r6_par_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        par_cnt <= PAR_LIM);

endmodule

// File: rtl/rs_parity_lfsr.sv
// Division LFSR over GF(2^8): accumulates the remainder over message bytes
// and shifts it out, highest degree first, over the check slots.
// Assumes slot and start come from rs_slot_tracker in the same cycle.
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int          NPAR       = 16,
    parameter logic [8:0]  FIELD_POLY = 9'h11D
) (
    input  logic       clk,
    input  logic       rst_n,
    input  slot_e      slot,
    input  logic       start,
    input  logic       last_par,
    input  logic [7:0] in_data,
    output logic [7:0] par_byte
);

    // Expand the product of (x + 2^i), i = 0..NPAR-1; index j is the x^j term.
    function automatic logic [NPAR:0][7:0] gen_coeffs();
        logic [NPAR:0][7:0] g;
        logic [7:0]         root;
        g    = '0;
        g[0] = 8'd1;
        root = 8'd1;
        for (int i = 0; i < NPAR; i++) begin
            for (int j = NPAR; j >= 1; j--)
                g[j] = g[j-1] ^ gf_mul(g[j], root, FIELD_POLY);
            g[0] = gf_mul(g[0], root, FIELD_POLY);
            root = gf_mul(root, 8'd2, FIELD_POLY);
        end
        return g;
    endfunction

    localparam logic [NPAR:0][7:0] GEN = gen_coeffs();

    logic [NPAR-1:0][7:0] rem_q;
    logic [NPAR-1:0][7:0] rem_d;
    logic [NPAR-1:0][7:0] base;
    logic [7:0]           fb;

    // Next remainder: divide on message bytes, plain shift on check slots.
    always_comb begin
        base  = start ? '0 : rem_q;
        fb    = in_data ^ base[NPAR-1];
        rem_d = rem_q;
        case (slot)
            SLOT_MSG: begin
                rem_d[0] = gf_mul(fb, GEN[0], FIELD_POLY);
                for (int j = 1; j < NPAR; j++)
                    rem_d[j] = base[j-1] ^ gf_mul(fb, GEN[j], FIELD_POLY);
            end
            SLOT_PAR: begin
                rem_d[0] = '0;
                for (int j = 1; j < NPAR; j++)
                    rem_d[j] = base[j-1];
            end
            default: ;
        endcase
    end

    // Hold the remainder register.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

    assign par_byte = rem_q[NPAR-1];

    a_r2_empty_after_last_check: assert property (@(posedge clk) disable iff (!rst_n)
        last_par |=> rem_q == '0);

endmodule

// File: rtl/rs_parity_inserter.sv
// Top: inserts Reed-Solomon check bytes into host-provided empty slots.
// Latency is 1 + EXTRA_STAGES cycles for data, valid and phase alike.
// Assumes bypass and span_mode change only between codewords.
module rs_parity_inserter
    import rs_enc_pkg::*;
#(
    parameter int         MSG_LEN      = 188,
    parameter int         NPAR         = 16,
    parameter logic [8:0] FIELD_POLY   = 9'h11D,
    parameter int         EXTRA_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bypass,
    input  logic       span_mode,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_phase,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_phase
);

    slot_e      slot;
    logic       start;
    logic       last_par;
    logic [7:0] par_byte;
    logic [7:0] s_data;
    logic       s_valid;
    logic       s_phase;
    logic [9:0] tail;

    rs_slot_tracker #(
        .MSG_LEN (MSG_LEN),
        .NPAR    (NPAR)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .span_mode (span_mode),
        .in_valid  (in_valid),
        .in_phase  (in_phase),
        .slot      (slot),
        .start     (start),
        .last_par  (last_par)
    );

    rs_parity_lfsr #(
        .NPAR       (NPAR),
        .FIELD_POLY (FIELD_POLY)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot     (slot),
        .start    (start),
        .last_par (last_par),
        .in_data  (in_data),
        .par_byte (par_byte)
    );

    // First output stage: substitute check bytes unless bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_data  <= '0;
            s_valid <= 1'b0;
            s_phase <= 1'b0;
        end else begin
            s_valid <= in_valid;
            s_phase <= in_phase;
            s_data  <= (!bypass && slot == SLOT_PAR) ? par_byte : in_data;
        end
    end

    rs_delay_line #(
        .W     (10),
        .DEPTH (EXTRA_STAGES)
    ) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({s_valid, s_phase, s_data}),
        .q     (tail)
    );

    assign {out_valid, out_phase, out_data} = tail;

    a_r5_bypass_passes_data: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(bypass) |-> s_data == $past(in_data));

    a_r3_check_slot_uses_remainder: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(bypass) && $past(slot) == SLOT_PAR |-> s_data == $past(par_byte));

endmodule

// File: tb/test_rs_parity_inserter.sv
module test_rs_parity_inserter;

    localparam int K   = 188;
    localparam int P   = 16;
    localparam int N   = K + P;
    localparam int LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bypass = 1'b0;
    logic       span_mode = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_phase = 1'b0;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_phase;

    rs_parity_inserter i_rs_parity_inserter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass    (bypass),
        .span_mode (span_mode),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_phase  (in_phase),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_phase (out_phase)
    );

    always #10 clk = ~clk;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] msg    [N];
    logic [7:0] exp_cw [N];
    logic [7:0] bgen   [P+1];
    logic [7:0] got_d  [512];
    logic       got_p  [512];
    int         got_n = 0;
    bit         cap_en = 1'b0;

    // Capture every valid output byte away from the active edge.
    always @(negedge clk) begin
        if (cap_en && out_valid && got_n < 512) begin
            got_d[got_n] = out_data;
            got_p[got_n] = out_phase;
            got_n++;
        end
    end

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h11D << (i - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] bpow(input int e);
        logic [7:0] r;
        r = 8'd1;
        for (int i = 0; i < e; i++) r = bmul(r, 8'd2);
        return r;
    endfunction

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Generator as a product of (x + 2^i), bgen[j] is the x^j term.
    task automatic build_gen();
        logic [7:0] nxt [P+1];
        for (int j = 0; j <= P; j++) bgen[j] = (j == 0) ? 8'd1 : 8'd0;
        for (int i = 0; i < P; i++) begin
            for (int j = 0; j <= P; j++)
                nxt[j] = bmul(bgen[j], bpow(i)) ^ ((j > 0) ? bgen[j-1] : 8'd0);
            for (int j = 0; j <= P; j++) bgen[j] = nxt[j];
        end
    endtask

    // Fill the message from a seed and compute the expected codeword by long division.
    task automatic make_cw(input int seed);
        logic [7:0] work [N];
        int unsigned s;
        logic [7:0] coef;
        s = 32'(seed) * 32'd2654435761 + 32'd7;
        for (int i = 0; i < N; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            msg[i]  = (i < K) ? s[23:16] : 8'd0;
            work[i] = msg[i];
        end
        for (int i = 0; i < K; i++) begin
            coef = work[i];
            for (int j = 1; j <= P; j++) work[i+j] = work[i+j] ^ bmul(coef, bgen[P-j]);
        end
        for (int i = 0; i < N; i++) exp_cw[i] = (i < K) ? msg[i] : work[i];
    endtask

    task automatic send_cw(input bit mode, input bit byp, input logic [7:0] filler,
                           input int gap);
        span_mode = mode;
        bypass    = byp;
        got_n     = 0;
        cap_en    = 1'b1;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_phase = mode ? 1'b1 : (i < K);
            in_data  = (i < K) ? msg[i] : (filler ^ 8'(i));
            if (gap > 0 && (i % gap) == gap - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = 8'h3C;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_phase = 1'b0;
        in_data  = '0;
        repeat (LAT + 1) @(negedge clk);
        cap_en = 1'b0;
    endtask

    task automatic verify_cw(input bit mode, input bit byp, input logic [7:0] filler,
                             input string req);
        int         bad;
        int         first;
        logic [7:0] e;
        logic [7:0] syn;
        int         bad_syn;
        check(got_n == N, req, "output byte count", got_n, N);
        bad = 0;
        first = -1;
        for (int i = 0; i < N && i < got_n; i++) begin
            e = (byp && i >= K) ? (filler ^ 8'(i)) : exp_cw[i];
            if (got_d[i] !== e || got_p[i] !== (mode ? 1'b1 : (i < K))) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0) begin
            e = (byp && first >= K) ? (filler ^ 8'(first)) : exp_cw[first];
            check(1'b0, req, $sformatf("byte %0d (%0d mismatches)", first, bad),
                  int'(got_d[first]), int'(e));
        end else begin
            check(1'b1, req, "codeword bytes", 0, 0);
        end
        if (!byp) begin
            bad_syn = 0;
            for (int r = 0; r < P; r++) begin
                syn = '0;
                for (int i = 0; i < N; i++) syn = bmul(syn, bpow(r)) ^ got_d[i];
                if (syn != 0) bad_syn++;
            end
            check(bad_syn == 0, "R2", "nonzero syndromes", bad_syn, 0);
        end
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_phase = 1'b1;
        in_data  = 8'hA5;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_phase === 1'b0, "R1", "out_phase in reset", int'(out_phase), 0);
        check(out_data === 8'h00, "R1", "out_data in reset", int'(out_data), 0);
        in_valid = 1'b0;
        in_phase = 1'b0;
        in_data  = '0;
        rst_n    = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_latency();
        int n;
        @(negedge clk);
        in_valid = 1'b1;
        in_phase = 1'b1;
        in_data  = 8'h5A;
        n = 0;
        @(negedge clk);
        in_valid = 1'b0;
        in_phase = 1'b0;
        in_data  = '0;
        n = 1;
        while (!out_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(n == LAT, "R4", "latency in cycles", n, LAT);
        check(out_data == 8'h5A, "R4", "delayed data", int'(out_data), 8'h5A);
        check(out_phase == 1'b1, "R4", "delayed phase", int'(out_phase), 1);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_mode_phase_drop();
        make_cw(1);
        send_cw(1'b0, 1'b0, 8'h11, 0);
        verify_cw(1'b0, 1'b0, 8'h11, "R6");
    endtask

    task automatic t_mode_phase_span();
        make_cw(2);
        send_cw(1'b1, 1'b0, 8'h99, 0);
        verify_cw(1'b1, 1'b0, 8'h99, "R7");
    endtask

    task automatic t_filler_ignored();
        make_cw(3);
        send_cw(1'b0, 1'b0, 8'h00, 0);
        verify_cw(1'b0, 1'b0, 8'h00, "R3");
        send_cw(1'b0, 1'b0, 8'hFF, 0);
        verify_cw(1'b0, 1'b0, 8'hFF, "R3");
    endtask

    task automatic t_bypass();
        make_cw(4);
        send_cw(1'b0, 1'b1, 8'h77, 0);
        verify_cw(1'b0, 1'b1, 8'h77, "R5");
        bypass = 1'b0;
    endtask

    task automatic t_gaps();
        make_cw(5);
        send_cw(1'b0, 1'b0, 8'h42, 7);
        verify_cw(1'b0, 1'b0, 8'h42, "R9");
        make_cw(6);
        send_cw(1'b1, 1'b0, 8'h24, 5);
        verify_cw(1'b1, 1'b0, 8'h24, "R9");
    endtask

    task automatic t_restart();
        span_mode = 1'b0;
        make_cw(7);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_phase = 1'b1;
            in_data  = msg[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_phase = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        make_cw(8);
        send_cw(1'b0, 1'b0, 8'h5E, 0);
        verify_cw(1'b0, 1'b0, 8'h5E, "R8");
    endtask

    task automatic t_outside();
        logic [7:0] extra [3];
        extra[0] = 8'hC3;
        extra[1] = 8'h00;
        extra[2] = 8'h81;
        got_n  = 0;
        cap_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_phase = 1'b0;
            in_data  = extra[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        repeat (LAT + 1) @(negedge clk);
        cap_en = 1'b0;
        check(got_n == 3, "R10", "trailing byte count", got_n, 3);
        for (int i = 0; i < 3 && i < got_n; i++) begin
            check(got_d[i] == extra[i], "R10", "trailing byte", int'(got_d[i]), int'(extra[i]));
            check(got_p[i] == 1'b0, "R10", "trailing phase", int'(got_p[i]), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        build_gen();
        t_reset();
        t_latency();
        t_mode_phase_drop();
        t_mode_phase_span();
        t_filler_ignored();
        t_bypass();
        t_gaps();
        t_restart();
        t_outside();
        finish_sim();
    end

endmodule